// File: doc/BRIEF.md
# Hot-Plug and Power-Event Interrupt Signalling Unit

This block sits inside a PCI Express root port. It gathers a set of hot-plug event sources and a set of power-management event sources into one interrupt output. Each source has an enable input and a status bit. An event pulse sets a status bit, but only while that source's enable is high. Software clears status bits by writing ones to them.

A mode input picks one of two mutually exclusive ways to signal. In legacy mode a level wire is high while any status bit is set. In message-signalled mode the block raises a send-message request. The request stays high until the consumer accepts it with a ready strobe. A message is requested when a status bit newly sets. A message is also requested when software clears some of the set bits but others remain set. Building the message packet, routing the wire to an interrupt controller and decoding configuration space all sit outside this block.

Top module: `hpme_irq_unit`

## Requirements
- R1: A status bit sets on a cycle when its event input and its enable input are both high. An event seen while the enable is low leaves the bit unchanged. Hot-plug sources occupy status bits [NUM_HP-1:0]. Power-management sources occupy the bits above them.
- R2: When `clr_we_i` is high, every status bit whose `clr_mask_i` bit is 1 is cleared. Bits whose mask bit is 0 keep their value.
- R3: If a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R4: When `msi_en_i` is low, `intx_o` is high in the cycle after any update that leaves at least one status bit set. It is low after any update that leaves all status bits zero.
- R5: While `msi_en_i` is high, `intx_o` is low in the following cycle. While `msi_en_i` is low, `msg_req_o` is low in the following cycle, and any pending request is dropped.
- R6: In message mode, an update in which at least one status bit goes from 0 to 1 produces a message request.
- R7: In message mode, a software clear that removes at least one set bit requests a message when some status bit is still set afterwards. A clear that leaves all status bits zero requests no message.
- R8: In message mode, a software clear and a hardware set of status bits in the same cycle request a message. This holds even when the set lands on the bit being cleared.
- R9: `msg_req_o` stays high until it is accepted, meaning `msg_ack_i` is high in the same cycle. New triggers that arrive while a request is pending merge into that request. A trigger in the cycle of acceptance keeps `msg_req_o` high.
- R10: A synchronous active-high `rst_i` clears all status bits, `intx_o` and `msg_req_o`. Every output is registered and reflects the inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| msi_en_i | input | 1 | 1 = message mode, 0 = legacy wire mode |
| hp_evt_i | input | NUM_HP | Hot-plug event pulses |
| hp_en_i | input | NUM_HP | Hot-plug source enables |
| pm_evt_i | input | NUM_PM | Power-management event pulses |
| pm_en_i | input | NUM_PM | Power-management source enables |
| clr_we_i | input | 1 | Software write-one-to-clear strobe |
| clr_mask_i | input | NUM_HP+NUM_PM | Bits to clear when the strobe is high |
| msg_ack_i | input | 1 | Consumer accepts the pending message |
| status_o | output | NUM_HP+NUM_PM | Current status bits |
| intx_o | output | 1 | Legacy level interrupt wire |
| msg_req_o | output | 1 | Pending send-message request |

## Verification
The assertions assume that `msi_en_i` and `msg_ack_i` are valid on every clock after reset. They also assume `msg_ack_i` is only meaningful while a request is pending, so an acknowledge with no pending request is simply ignored. They make no assumption about how often events arrive or how the clear mask relates to the status bits.

The random stimulus drives events, enables, clear strobes with arbitrary masks, the acknowledge and occasional mode changes freely. This covers clears of bits that are already zero and sets of bits that are already set. Directed steps walk through each row of the wire-versus-message behaviour before the random phase starts.

// File: rtl/hpme_pkg.sv
package hpme_pkg;
  typedef struct packed {
    logic trig;   // message-worthy change this cycle
    logic any;    // some status bit set after the update
  } hpme_evt_t;
endpackage

// File: rtl/hpme_status_bank.sv
module hpme_status_bank #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] status_nxt_o
);
  logic [NUM_SRC-1:0] clr_eff;
  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic bit_q;
    logic bit_d;
    always_comb begin
      bit_d = bit_q;
      if (clr_eff[i]) bit_d = 1'b0;
      if (set_i[i])   bit_d = 1'b1;   // set wins over clear
    end
    always_ff @(posedge clk_i) begin
      if (rst_i) bit_q <= 1'b0;
      else       bit_q <= bit_d;
    end
    assign status_o[i]     = bit_q;
    assign status_nxt_o[i] = bit_d;

    a_r3_set_wins: assert property (@(posedge clk_i) disable iff (rst_i)
      set_i[i] |=> status_o[i]);
    a_r2_clear_bit: assert property (@(posedge clk_i) disable iff (rst_i)
      (clr_we_i && clr_mask_i[i] && !set_i[i]) |=> !status_o[i]);
  end
endmodule

// File: rtl/hpme_event_detect.sv
module hpme_event_detect
  import hpme_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] status_nxt_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output hpme_evt_t          evt_o
);
  logic newly_set;
  logic touched_clear;
  always_comb begin
    newly_set     = |(set_i & ~status_i);
    touched_clear = clr_we_i && |(status_i & clr_mask_i);
    evt_o.any     = |status_nxt_i;
    evt_o.trig    = evt_o.any && (newly_set || touched_clear);
  end
endmodule

// File: rtl/hpme_output_stage.sv
module hpme_output_stage
  import hpme_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      msi_en_i,
  input  hpme_evt_t evt_i,
  input  logic      msg_ack_i,
  output logic      intx_o,
  output logic      msg_req_o
);
  logic intx_q, pend_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      intx_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      intx_q <= !msi_en_i && evt_i.any;
      pend_q <= msi_en_i && ((pend_q && !msg_ack_i) || evt_i.trig);
    end
  end
  assign intx_o    = intx_q;
  assign msg_req_o = pend_q;

  a_r5_wire_off_in_msi: assert property (@(posedge clk_i) disable iff (rst_i)
    msi_en_i |=> !intx_o);
  a_r5_no_req_legacy: assert property (@(posedge clk_i) disable iff (rst_i)
    !msi_en_i |=> !msg_req_o);
  a_r9_hold_pending: assert property (@(posedge clk_i) disable iff (rst_i)
    (msg_req_o && !msg_ack_i && msi_en_i) |=> msg_req_o);
  a_r9_trig_raises: assert property (@(posedge clk_i) disable iff (rst_i)
    (msi_en_i && evt_i.trig) |=> msg_req_o);
endmodule

// File: rtl/hpme_irq_unit.sv
module hpme_irq_unit
  import hpme_pkg::*;
#(
  parameter int NUM_HP = 3,
  parameter int NUM_PM = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     msi_en_i,
  input  logic [NUM_HP-1:0]        hp_evt_i,
  input  logic [NUM_HP-1:0]        hp_en_i,
  input  logic [NUM_PM-1:0]        pm_evt_i,
  input  logic [NUM_PM-1:0]        pm_en_i,
  input  logic                     clr_we_i,
  input  logic [NUM_HP+NUM_PM-1:0] clr_mask_i,
  input  logic                     msg_ack_i,
  output logic [NUM_HP+NUM_PM-1:0] status_o,
  output logic                     intx_o,
  output logic                     msg_req_o
);
  localparam int NUM_SRC = NUM_HP + NUM_PM;

  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] status_nxt;
  hpme_evt_t          evt;

  assign set_vec = {pm_evt_i & pm_en_i, hp_evt_i & hp_en_i};

  hpme_status_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk_i(clk_i), .rst_i(rst_i), .set_i(set_vec),
    .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i),
    .status_o(status_o), .status_nxt_o(status_nxt)
  );

  hpme_event_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .status_i(status_o), .status_nxt_i(status_nxt), .set_i(set_vec),
    .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i), .evt_o(evt)
  );

  hpme_output_stage u_out (
    .clk_i(clk_i), .rst_i(rst_i), .msi_en_i(msi_en_i), .evt_i(evt),
    .msg_ack_i(msg_ack_i), .intx_o(intx_o), .msg_req_o(msg_req_o)
  );

  a_r4_wire_tracks_status: assert property (@(posedge clk_i) disable iff (rst_i)
    !msi_en_i |=> (intx_o == (|status_o)));
  a_r7_no_msg_when_empty: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_o == '0 && !msg_req_o) |-> !intx_o);
  a_r1_gated_event: assert property (@(posedge clk_i) disable iff (rst_i)
    (hp_evt_i[0] && !hp_en_i[0] && !status_o[0]) |=> !status_o[0]);
endmodule

// File: tb/tb_hpme_irq_unit.sv
module tb_hpme_irq_unit;
  localparam int HP = 3;
  localparam int PM = 2;
  localparam int N  = HP + PM;

  logic clk = 1'b0;
  logic rst, msi_en, clr_we, ack;
  logic [HP-1:0] hp_evt, hp_en;
  logic [PM-1:0] pm_evt, pm_en;
  logic [N-1:0] clr_mask, status;
  logic intx, req;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] m_status;
  logic m_intx, m_req;

  always #4 clk = ~clk;

  hpme_irq_unit #(.NUM_HP(HP), .NUM_PM(PM)) dut (
    .clk_i(clk), .rst_i(rst), .msi_en_i(msi_en),
    .hp_evt_i(hp_evt), .hp_en_i(hp_en), .pm_evt_i(pm_evt), .pm_en_i(pm_en),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask), .msg_ack_i(ack),
    .status_o(status), .intx_o(intx), .msg_req_o(req)
  );

  function automatic logic [N-1:0] f_next(logic [N-1:0] s, logic [N-1:0] set,
                                          logic we, logic [N-1:0] mask);
    logic [N-1:0] r;
    r = we ? (s & ~mask) : s;
    return r | set;
  endfunction

  function automatic logic f_trig(logic [N-1:0] s, logic [N-1:0] set,
                                  logic we, logic [N-1:0] mask);
    logic [N-1:0] nx;
    nx = f_next(s, set, we, mask);
    if (nx == '0) return 1'b0;
    if ((set & ~s) != '0) return 1'b1;
    if (we && ((s & mask) != '0)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive at negedge, update model, wait one edge, check at next negedge.
  task automatic step(string tag, logic r, logic m, logic [HP-1:0] he, logic [HP-1:0] hen,
                      logic [PM-1:0] pe, logic [PM-1:0] pen, logic cw,
                      logic [N-1:0] cm, logic a);
    logic [N-1:0] set;
    logic t;
    rst = r; msi_en = m; hp_evt = he; hp_en = hen; pm_evt = pe; pm_en = pen;
    clr_we = cw; clr_mask = cm; ack = a;
    set = {pe & pen, he & hen};
    if (r) begin
      m_status = '0; m_intx = 1'b0; m_req = 1'b0;
    end else begin
      t = f_trig(m_status, set, cw, cm);
      m_status = f_next(m_status, set, cw, cm);
      m_intx = !m && (m_status != '0);
      m_req  = m && ((m_req && !a) || t);
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "status", 32'(status), 32'(m_status));
    chk(tag, "intx",   32'(intx),   32'(m_intx));
    chk(tag, "req",    32'(req),    32'(m_req));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [HP-1:0] E;
    logic [PM-1:0] P;
    E = '1; P = '1;
    m_status = '0; m_intx = 1'b0; m_req = 1'b0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    step("R10 reset", 1, 1, '1, '1, '1, '1, 0, '0, 0);
    step("R10 reset hold", 1, 0, '1, '1, '1, '1, 0, '0, 0);
    // message mode rows
    step("R6 first set", 0, 1, 3'b001, E, 2'b00, P, 0, '0, 0);
    step("R9 accept", 0, 1, '0, E, '0, P, 0, '0, 1);
    step("R6 another set", 0, 1, '0, E, 2'b01, P, 0, '0, 0);
    step("R9 holds", 0, 1, '0, E, '0, P, 0, '0, 0);
    step("R9 holds again", 0, 1, '0, E, '0, P, 0, '0, 0);
    step("R9 merge on accept", 0, 1, 3'b010, E, '0, P, 0, '0, 1);
    step("R9 accepted", 0, 1, '0, E, '0, P, 0, '0, 1);
    step("R7 partial clear", 0, 1, '0, E, '0, P, 1, 5'b00001, 0);
    step("R2 clear of zero bit", 0, 1, '0, E, '0, P, 1, 5'b00100, 1);
    step("R1 disabled event", 0, 1, 3'b100, 3'b011, '0, P, 0, '0, 0);
    step("R8 clear plus set", 0, 1, 3'b001, E, '0, P, 1, 5'b01000, 1);
    step("R3 set beats clear", 0, 1, 3'b010, E, '0, P, 1, 5'b00010, 1);
    step("R7 clear all", 0, 1, '0, E, '0, P, 1, '1, 1);
    step("R7 stays quiet", 0, 1, '0, E, '0, P, 0, '0, 0);
    // legacy mode
    step("R4 wire on", 0, 0, '0, E, 2'b10, P, 0, '0, 0);
    step("R5 no req legacy", 0, 0, 3'b001, E, '0, P, 0, '0, 0);
    step("R4 partial clear", 0, 0, '0, E, '0, P, 1, 5'b10000, 0);
    step("R4 wire off", 0, 0, '0, E, '0, P, 1, '1, 0);
    step("R4 set again", 0, 0, 3'b100, E, '0, P, 0, '0, 0);
    step("R5 msi forces wire low", 0, 1, '0, E, '0, P, 0, '0, 0);
    step("R5 drop pending", 0, 1, 3'b010, E, '0, P, 0, '0, 0);
    step("R5 legacy drops req", 0, 0, '0, E, '0, P, 0, '0, 0);
    step("R10 reset mid-run", 1, 0, '0, E, '0, P, 0, '0, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic m, cw, a;
      m  = ($urandom % 16) != 0;
      cw = ($urandom % 4) == 0;
      a  = ($urandom % 3) == 0;
      step("R6 random", ($urandom % 500) == 0, (i % 700) < 600 ? m : 1'b0,
           HP'(($urandom % 6 == 0) ? $urandom : 0), HP'($urandom | $urandom),
           PM'(($urandom % 6 == 0) ? $urandom : 0), PM'($urandom | $urandom),
           cw, N'($urandom), a);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule